// File: doc/BRIEF.md
# Column-Ordered Unsigned Multiplier

This block multiplies two unsigned operands of `W` bits each and gives the full `2W`-bit product with no clock and no state. It does not add rows of shifted partial products. It works through the product one column at a time, from the least significant column upward.

For column `k`, the block ANDs every operand bit pair `a[i]` and `b[j]` with `i + j = k`. It adds those bits to the carry from column `k-1`. The least significant bit of that column total becomes product bit `k`, and the remaining bits pass to column `k+1` as a carry that can be several bits wide.

With `W = 4` there are seven columns, 0 to 6. The carry left over after the last column becomes the top product bit. The block suits datapaths that want a compact, regular multiplier of small width between their own registers.

Top module: `colmul`

## Requirements
- R1: For every pair of operands, `p` equals the unsigned product `a * b` taken to `2W` bits.
- R2: Product bit 0 equals `a[0] & b[0]`.
- R3: Product bit 1 equals `(a[1] & b[0]) ^ (a[0] & b[1])`, the low bit of the column-1 total.
- R4: The carry passed out of any column is less than `W`. For `W = 4`, `a = b = 15` drives the widest column (four ones plus carry) and must still give 225.
- R5: Product bit `2W-1` is the carry left after column `2W-2`, and that carry is 0 or 1.
- R6: If either operand is zero, `p` is zero.
- R7: If one operand is 1, `p` equals the other operand, zero-extended.
- R8: `p` follows a change on `a` or `b` without any clock edge. A new operand pair gives its product within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | Unsigned multiplicand |
| b | input | W | Unsigned multiplier |
| p | output | 2W | Unsigned product |

## Verification
The embedded checks evaluate only when neither operand carries an unknown bit. They therefore assume that `a` and `b` are fully driven before anyone judges the product. They also assume that nothing samples `p` while the operands are still settling.

The bench drives every operand pair on a rising edge and compares on the falling edge. The inputs are always defined and have half a period to settle. For `W = 4` all 256 pairs are applied. The sweep includes the zero, unit and all-ones corners that stress the widest column carries.

// File: rtl/colmul.sv
module colmul #(
  parameter int W = 4
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  localparam int NCOL = 2*W - 1;
  localparam int SW   = $clog2(2*W) + 1;

  function automatic logic [SW-1:0] column_ones(input logic [W-1:0] x,
                                                input logic [W-1:0] y,
                                                input int k);
    logic [SW-1:0] n;
    n = '0;
    for (int i = 0; i < W; i++) begin
      if (k - i >= 0 && k - i < W)
        n = n + SW'(x[i] & y[k-i]);
    end
    return n;
  endfunction

  logic [SW-1:0] carry [NCOL+1];
  assign carry[0] = '0;

  genvar k;
  generate
    for (k = 0; k < NCOL; k++) begin : g_col
      logic [SW-1:0] total;
      assign total      = column_ones(a, b, k) + carry[k];
      assign p[k]       = total[0];
      assign carry[k+1] = total >> 1;
    end
  endgenerate

  assign p[2*W-1] = carry[NCOL][0];

  always_comb begin
    if (!$isunknown({a, b})) begin
      assert_product_R1: assert (p == (2*W)'({{W{1'b0}}, a} * {{W{1'b0}}, b}))
        else $error("product mismatch");
      assert_lsb_R2: assert (p[0] == (a[0] & b[0]))
        else $error("lsb mismatch");
      for (int c = 1; c <= NCOL; c++) begin
        assert_carry_bound_R4: assert (int'(carry[c]) < W)
          else $error("column carry too wide");
      end
      assert_top_carry_R5: assert (carry[NCOL] <= SW'(1))
        else $error("final carry above one");
      assert_zero_R6: assert (!(a == '0 || b == '0) || p == '0)
        else $error("zero operand gave nonzero product");
    end
  end
endmodule

// File: tb/test_colmul.sv
module test_colmul;
  localparam int W = 4;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] a, b;
  logic [2*W-1:0] p;
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  colmul #(.W(W)) i_colmul (.a(a), .b(b), .p(p));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 5000 && !done) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual cycle %0d expected done", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d: actual %0d expected %0d", req, a, b, act, exp);
    end
  endtask

  task automatic apply(input int x, input int y);
    @(posedge clk);
    a = W'(x);
    b = W'(y);
    @(negedge clk);
  endtask

  initial begin
    a = '0;
    b = '0;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R6 reset-state zero", p, 0);
    for (int x = 0; x < (1 << W); x++) begin
      for (int y = 0; y < (1 << W); y++) begin
        int ref_p;
        ref_p = x * y;
        apply(x, y);
        check("R1 R8 product", p, ref_p);
        check("R2 bit0", p[0], (x & 1) & (y & 1));
        check("R3 bit1", p[1], (((x >> 1) & y) ^ (x & (y >> 1))) & 1);
        if (x == 0 || y == 0) check("R6 zero operand", p, 0);
        if (x == 1) check("R7 unit a", p, y);
        if (y == 1) check("R7 unit b", p, x);
      end
    end
    apply((1 << W) - 1, (1 << W) - 1);
    check("R4 widest columns", p, ((1 << W) - 1) * ((1 << W) - 1));
    check("R5 top bit set", p[2*W-1], 1);
    apply(1 << (W - 1), 1 << (W - 1));
    check("R5 top bit clear", p[2*W-1], 0);
    a = W'(3);
    b = W'(5);
    #1;
    check("R8 no clock needed", p, 15);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule